// File: doc/BRIEF.md
# Event-Triggered GPIO Output Action Unit

This block owns a 32-bit general-purpose output register and lets four hardware event lines modify single bits of it without software running. Each event channel is configured by one byte of a 32-bit control word. The byte holds an enable flag, a two-bit operation code and a five-bit target bit index. When an enabled channel fires, its operation is applied to the chosen output bit. The four operations are: drive from the event level, set, clear and invert.

Software reaches the block through a small register port. Address 0 is the control word and address 1 is the output register. Writes take effect on the next clock edge, and reads return the current contents combinationally. The event lines carry no handshake. A set, clear or invert action is triggered by a single-cycle high pulse. The drive-from-level operation copies the channel's input level into the target bit on every clock while the channel is enabled. There is no streaming data path here, so the register port and the event lines are plain control pins.

When channels collide on one bit, the rule is fixed. The highest-numbered enabled channel wins. An event action always beats a same-cycle software write for the bit it touches.

Top module: `gpio_evt_unit`

## Requirements
- R1: After reset, the output register and the control word both read 0 and `gpio_out` is 0.
- R2: A write with `reg_addr`=0 loads the control word and a write with `reg_addr`=1 loads the output register, both on the next clock edge. `reg_rdata` shows the addressed register in the same cycle.
- R3: Channel x is configured by control bits [8x+7:8x]. In that byte, bit 7 is the enable, bits 6:5 are the operation code and bits 4:0 are the target bit index (0 to 31).
- R4: A channel whose enable bit is 0 never changes the output register, whatever its event line does.
- R5: Operation code 1 sets the target bit to 1 on the clock edge that samples the event pulse. The change is visible one cycle after the pulse is driven.
- R6: Operation code 2 clears the target bit to 0 on the edge that samples the event pulse.
- R7: Operation code 3 inverts the target bit once for each sampled event pulse. Cycles without a pulse leave the bit unchanged.
- R8: Operation code 0 copies the channel's event level into the target bit on every clock edge while the channel is enabled.
- R9: If several enabled channels act on the same bit in one cycle, only the highest-numbered of them takes effect.
- R10: Enabled channels that act on different bits in one cycle all take effect together.
- R11: If a software write to the output register and an event action hit the same bit in the same cycle, the event action decides that bit. The written data still loads every other bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 control word, 1 output register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the addressed register |
| evt_in | input | 4 | Event lines, one per channel |
| gpio_out | output | 32 | Output register contents |

## Verification
The set, clear and invert operations are each driven with isolated single-cycle pulses. The invert test also repeats its pulse with idle gaps in between, which separates edge-counting behaviour from level behaviour. The drive-from-level operation is held high and low over several cycles and is then disabled, which shows whether the bit tracks the line continuously and whether it stops once the enable drops. Channels are fired together twice: first on one shared bit, with the winning channel's operation swapped between the two runs so that only priority decides the result, then on four distinct bits so that a lost update shows up. Finally, an event is made to coincide with a full-width software write, which shows the per-bit override against the rest of the written word.

// File: rtl/gpio_evt_pkg.sv
package gpio_evt_pkg;

  localparam int NUM_CH    = 4;
  localparam int OUT_W     = 32;
  localparam int LANE_W    = 8;
  localparam int PIN_W     = $clog2(OUT_W);
  localparam int CTRL_W    = NUM_CH * LANE_W;

  typedef enum logic [1:0] {
    OP_LEVEL  = 2'd0,
    OP_SET    = 2'd1,
    OP_CLEAR  = 2'd2,
    OP_INVERT = 2'd3
  } evt_op_e;

  // one control byte: enable in bit 7, op in 6:5, bit index in 4:0
  typedef struct packed {
    logic             en;
    evt_op_e          op;
    logic [PIN_W-1:0] idx;
  } lane_cfg_t;

  typedef enum logic {
    ADDR_CTRL = 1'b0,
    ADDR_OUT  = 1'b1
  } reg_sel_e;

endpackage

// File: rtl/gpio_evt_lane.sv
module gpio_evt_lane
  import gpio_evt_pkg::*;
(
  input  lane_cfg_t        cfg,
  input  logic             evt,
  input  logic [OUT_W-1:0] cur_out,
  output logic             hit,
  output logic [PIN_W-1:0] tgt,
  output logic             val
);

  always_comb begin
    tgt = cfg.idx;
    hit = 1'b0;
    val = 1'b0;
    if (cfg.en) begin
      unique case (cfg.op)
        OP_LEVEL:  begin hit = 1'b1; val = evt;               end
        OP_SET:    begin hit = evt;  val = 1'b1;              end
        OP_CLEAR:  begin hit = evt;  val = 1'b0;              end
        OP_INVERT: begin hit = evt;  val = ~cur_out[cfg.idx]; end
        default:   begin hit = 1'b0; val = 1'b0;              end
      endcase
    end
  end

endmodule

// File: rtl/gpio_evt_merge.sv
module gpio_evt_merge
  import gpio_evt_pkg::*;
#(
  parameter int N_CH = NUM_CH
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      sw_we,
  input  logic [OUT_W-1:0]          sw_data,
  input  logic [N_CH-1:0]           lane_hit,
  input  logic [N_CH-1:0][PIN_W-1:0] lane_tgt,
  input  logic [N_CH-1:0]           lane_val,
  output logic [OUT_W-1:0]          out_q
);

  logic [OUT_W-1:0] out_d;

  // software write forms the base; lanes overlay in ascending order so the
  // highest-numbered active lane is the last writer of a shared bit
  always_comb begin
    out_d = sw_we ? sw_data : out_q;
    for (int c = 0; c < N_CH; c++) begin
      if (lane_hit[c]) out_d[lane_tgt[c]] = lane_val[c];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_q <= '0;
    else        out_q <= out_d;
  end

endmodule

// File: rtl/gpio_evt_regs.sv
module gpio_evt_regs
  import gpio_evt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic              addr,
  input  logic [CTRL_W-1:0] wdata,
  input  logic [OUT_W-1:0]  out_q,
  output logic [CTRL_W-1:0] ctrl_q,
  output logic              out_we,
  output logic [OUT_W-1:0]  rdata
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          ctrl_q <= '0;
    else if (wr && addr == ADDR_CTRL)    ctrl_q <= wdata;
  end

  assign out_we = wr && (addr == ADDR_OUT);

  always_comb begin
    rdata = (addr == ADDR_OUT) ? out_q : OUT_W'(ctrl_q);
  end

endmodule

// File: rtl/gpio_evt_unit.sv
module gpio_evt_unit
  import gpio_evt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_addr,
  input  logic [OUT_W-1:0]  reg_wdata,
  output logic [OUT_W-1:0]  reg_rdata,
  input  logic [NUM_CH-1:0] evt_in,
  output logic [OUT_W-1:0]  gpio_out
);

  logic [CTRL_W-1:0]              ctrl_q;
  logic                           out_we;
  logic [OUT_W-1:0]               out_q;
  logic [NUM_CH-1:0]              lane_hit;
  logic [NUM_CH-1:0][PIN_W-1:0]   lane_tgt;
  logic [NUM_CH-1:0]              lane_val;

  gpio_evt_regs u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr     (reg_wr),
    .addr   (reg_addr),
    .wdata  (reg_wdata),
    .out_q  (out_q),
    .ctrl_q (ctrl_q),
    .out_we (out_we),
    .rdata  (reg_rdata)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_lane
    lane_cfg_t cfg;
    assign cfg = lane_cfg_t'(ctrl_q[c*LANE_W +: LANE_W]);
    gpio_evt_lane u_lane (
      .cfg     (cfg),
      .evt     (evt_in[c]),
      .cur_out (out_q),
      .hit     (lane_hit[c]),
      .tgt     (lane_tgt[c]),
      .val     (lane_val[c])
    );
  end

  gpio_evt_merge #(.N_CH(NUM_CH)) u_merge (
    .clk      (clk),
    .rst_n    (rst_n),
    .sw_we    (out_we),
    .sw_data  (reg_wdata),
    .lane_hit (lane_hit),
    .lane_tgt (lane_tgt),
    .lane_val (lane_val),
    .out_q    (out_q)
  );

  assign gpio_out = out_q;

endmodule

// File: rtl/gpio_evt_unit_chk.sv
module gpio_evt_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_wr,
  input logic        reg_addr,
  input logic [31:0] reg_wdata,
  input logic [3:0]  evt_in,
  input logic [31:0] gpio_out,
  input logic [31:0] ctrl_q
);

  logic any_en;
  assign any_en = ctrl_q[7] | ctrl_q[15] | ctrl_q[23] | ctrl_q[31];

  // with all channels off and no output write, the output holds
  assert_idle_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!any_en && !(reg_wr && reg_addr)) |=> gpio_out == $past(gpio_out));

  // with all channels off, a software write lands whole
  assert_sw_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!any_en && reg_wr && reg_addr) |=> gpio_out == $past(reg_wdata));

  // channel 3 always has priority, so its actions are visible directly
  assert_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[31] && ctrl_q[30:29] == 2'd1 && evt_in[3])
      |=> gpio_out[$past(ctrl_q[28:24])] == 1'b1);

  assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[31] && ctrl_q[30:29] == 2'd2 && evt_in[3])
      |=> gpio_out[$past(ctrl_q[28:24])] == 1'b0);

  assert_invert_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[31] && ctrl_q[30:29] == 2'd3 && evt_in[3])
      |=> gpio_out[$past(ctrl_q[28:24])] != $past(gpio_out[ctrl_q[28:24]]));

  assert_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[31] && ctrl_q[30:29] == 2'd0)
      |=> gpio_out[$past(ctrl_q[28:24])] == $past(evt_in[3]));

endmodule

bind gpio_evt_unit gpio_evt_unit_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_wr    (reg_wr),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .evt_in    (evt_in),
  .gpio_out  (gpio_out),
  .ctrl_q    (ctrl_q)
);

// File: tb/gpio_evt_unit_tb.sv
module gpio_evt_unit_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic        reg_addr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [3:0]  evt_in = '0;
  logic [31:0] gpio_out;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  gpio_evt_unit u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .evt_in    (evt_in),
    .gpio_out  (gpio_out)
  );

  function automatic logic [7:0] lane(input bit en, input logic [1:0] op, input logic [4:0] idx);
    return {en, op, idx};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic pulse(input logic [3:0] m);
    @(negedge clk);
    evt_in = m;
    @(negedge clk);
    evt_in = '0;
  endtask

  task automatic setup(input logic [31:0] c, input logic [31:0] o);
    evt_in = '0;
    wr(1'b0, 32'h0);
    wr(1'b1, o);
    wr(1'b0, c);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 gpio_out", gpio_out, 32'h0);
    rd(1'b0, d); chk("R1 ctrl read", d, 32'h0);
    rd(1'b1, d); chk("R1 out read", d, 32'h0);
  endtask

  task automatic t_regs();
    logic [31:0] d;
    wr(1'b0, 32'h1E5A_3C60);
    rd(1'b0, d); chk("R2 ctrl readback", d, 32'h1E5A_3C60);
    wr(1'b0, 32'h0);
    wr(1'b1, 32'hDEAD_BEEF);
    chk("R2 gpio_out after write", gpio_out, 32'hDEAD_BEEF);
    rd(1'b1, d); chk("R2 out readback", d, 32'hDEAD_BEEF);
  endtask

  task automatic t_disabled();
    // lane0 disabled set on 3, lane1 disabled level on 5
    setup({16'h0, lane(0, 2'd0, 5'd5), lane(0, 2'd1, 5'd3)}, 32'h0);
    pulse(4'b0001);
    chk("R4 disabled set", gpio_out, 32'h0);
    @(negedge clk); evt_in = 4'b0010;
    repeat (2) @(negedge clk);
    chk("R4 disabled level", gpio_out, 32'h0);
    evt_in = '0;
  endtask

  task automatic t_set();
    setup({8'h0, lane(1, 2'd1, 5'd17), 16'h0}, 32'h0);
    @(negedge clk); evt_in = 4'b0100;
    #1 chk("R5 no change before edge", gpio_out, 32'h0);
    @(negedge clk); evt_in = '0;
    chk("R5 set via lane 2 (R3 layout)", gpio_out, 32'h0002_0000);
  endtask

  task automatic t_clear();
    setup({16'h0, lane(1, 2'd2, 5'd31), 8'h0}, 32'hFFFF_FFFF);
    pulse(4'b0010);
    chk("R6 clear bit 31", gpio_out, 32'h7FFF_FFFF);
  endtask

  task automatic t_invert();
    setup({24'h0, lane(1, 2'd3, 5'd0)}, 32'h0);
    pulse(4'b0001); chk("R7 invert 1", gpio_out, 32'h1);
    @(negedge clk); chk("R7 idle hold", gpio_out, 32'h1);
    pulse(4'b0001); chk("R7 invert 2", gpio_out, 32'h0);
    pulse(4'b0001); chk("R7 invert 3", gpio_out, 32'h1);
  endtask

  task automatic t_level();
    setup({lane(1, 2'd0, 5'd9), 24'h0}, 32'h0);
    @(negedge clk); evt_in = 4'b1000;
    @(negedge clk); chk("R8 follows high", gpio_out, 32'h0000_0200);
    @(negedge clk); chk("R8 stays high", gpio_out, 32'h0000_0200);
    evt_in = '0;
    @(negedge clk); chk("R8 follows low", gpio_out, 32'h0);
    wr(1'b0, 32'h0);
    evt_in = 4'b1000;
    repeat (2) @(negedge clk);
    chk("R4 level disabled", gpio_out, 32'h0);
    evt_in = '0;
  endtask

  task automatic t_collide();
    // lane0 clears 4, lane1 sets 4: lane1 wins
    setup({16'h0, lane(1, 2'd1, 5'd4), lane(1, 2'd2, 5'd4)}, 32'h0);
    pulse(4'b0011);
    chk("R9 higher sets", gpio_out, 32'h10);
    // lane0 sets 4, lane2 clears 4: lane2 wins
    setup({8'h0, lane(1, 2'd2, 5'd4), 8'h0, lane(1, 2'd1, 5'd4)}, 32'h10);
    pulse(4'b0101);
    chk("R9 higher clears", gpio_out, 32'h0);
  endtask

  task automatic t_parallel();
    setup({lane(1, 2'd2, 5'd20), lane(1, 2'd3, 5'd12),
           lane(1, 2'd1, 5'd7), lane(1, 2'd1, 5'd2)}, 32'h0010_0000);
    pulse(4'b1111);
    chk("R10 four bits at once", gpio_out, 32'h0000_1084);
  endtask

  task automatic t_override();
    setup({16'h0, lane(1, 2'd1, 5'd6), 8'h0}, 32'h0);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 1'b1; reg_wdata = 32'hFFFF_0000; evt_in = 4'b0010;
    @(negedge clk);
    reg_wr = 1'b0; evt_in = '0;
    chk("R11 event sets over write", gpio_out, 32'hFFFF_0040);
    setup({16'h0, lane(1, 2'd2, 5'd6), 8'h0}, 32'h0);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 1'b1; reg_wdata = 32'hFFFF_FFFF; evt_in = 4'b0010;
    @(negedge clk);
    reg_wr = 1'b0; evt_in = '0;
    chk("R11 event clears over write", gpio_out, 32'hFFFF_FFBF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_disabled();
    t_set();
    t_clear();
    t_invert();
    t_level();
    t_collide();
    t_parallel();
    t_override();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule